// File: doc/BRIEF.md
# Channel-Parallel Multiply-Accumulate Engine

This engine is the arithmetic core of a convolution or transposed-convolution tile. Each valid cycle it takes one vector of input pixels, one for every input channel, and one weight matrix indexed by output channel and input channel. It also takes the tile address of the output position that the index generator has worked out for the current kernel offset. Every output channel multiplies the pixels by its own weight row, and a pipelined adder tree reduces the products over the input channels. The engine then adds that sum into a tile buffer that holds one bank per output channel, so all output channels update in the same cycle.

A holding register keeps the running sum of the address last written. A run of operations on one address stays in that register, and the bank is written only when the address changes. Operations on the same address may follow one or two cycles apart. A clear pulse empties the tile before the next tile starts. The drain port reads one address at a time and returns every channel rounded and saturated back to the operand width.

The array holds NOC times NIC multipliers. That product must fit in the multipliers the target provides, and the operand width must stay at or below 18 bits.

Top module: `chan_mac_engine`

## Requirements
- R1: After reset, `rd_vld` is low, and a drain read of any tile address returns zero on every channel.
- R2: One valid operation adds, for each output channel o, the sum over i of px[i]×wt[o][i] to the tile entry at `in_addr`. Pixel i sits at `px[i*DW +: DW]`, weight (o,i) at `wt[(o*NIC+i)*DW +: DW]`, and channel o of the drain result at `rd_q[o*DW +: DW]`. All are two's-complement values with FRAC fraction bits.
- R3: Operations on the same address separated by idle cycles accumulate.
- R4: Operations on the same address in consecutive cycles accumulate with no lost update.
- R5: Two addresses interleaved cycle by cycle (A, B, A, B, A) each accumulate exactly their own operations.
- R6: A one-cycle `clr` pulse, given while no operation is in flight, makes every address read zero, including the address held in the holding register.
- R7: Drain rounds the accumulator, which carries 2×FRAC fraction bits, to FRAC fraction bits by adding half an LSB and shifting right arithmetically (ties round toward positive).
- R8: Drain saturates each channel to the signed DW-bit range [-2^(DW-1), 2^(DW-1)-1]. `rd_vld` and `rd_q` appear on the cycle after `rd_en`.
- R9: While `in_vld` is low, the values on `px`, `wt` and `in_addr` leave the tile unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Empty the tile buffer |
| in_vld | input | 1 | Operation valid |
| in_addr | input | AW | Output tile address of the operation |
| px | input | NIC*DW | Input pixel vector |
| wt | input | NOC*NIC*DW | Weight matrix, output channel major |
| rd_en | input | 1 | Drain read request |
| rd_addr | input | AW | Drain read address |
| rd_vld | output | 1 | Drain data valid |
| rd_q | output | NOC*DW | Rounded, saturated channel results |

## Verification
The bench targets the accumulate hazards. It sends back-to-back operations on one address, where a design that re-read the bank would drop all but one partial sum. It also sends A/B interleaving at distance two, where a late bank write would return a stale base. It clears the tile while a sum still sits in the holding register, which a design clearing only the banks would leak into the next tile. It probes rounding exactly at and just below the half-LSB tie, and pushes large positive and negative sums past the output range, where a wrapping design would flip the sign.

// File: rtl/chan_mac_engine.sv
module chan_mac_engine #(
  parameter int NOC   = 4,
  parameter int NIC   = 4,
  parameter int DW    = 12,
  parameter int FRAC  = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LV   = $clog2(NIC),
  localparam int ACCW = 2*DW + LV + 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  in_vld,
  input  logic [AW-1:0]         in_addr,
  input  logic [NIC*DW-1:0]     px,
  input  logic [NOC*NIC*DW-1:0] wt,
  input  logic                  rd_en,
  input  logic [AW-1:0]         rd_addr,
  output logic                  rd_vld,
  output logic [NOC*DW-1:0]     rd_q
);

  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (FRAC-1);
  localparam logic signed [ACCW-1:0] OMAX = ACCW'((1 << (DW-1)) - 1);
  localparam logic signed [ACCW-1:0] OMIN = -ACCW'(1 << (DW-1));

  function automatic logic signed [ACCW-1:0] mul(logic signed [DW-1:0] a, logic signed [DW-1:0] b);
    logic signed [2*DW-1:0] p;
    p = a * b;
    return ACCW'(p);
  endfunction

  function automatic logic [DW-1:0] narrow(logic signed [ACCW-1:0] v);
    logic signed [ACCW-1:0] s;
    s = (v + HALF) >>> FRAC;
    if (s > OMAX) return OMAX[DW-1:0];
    if (s < OMIN) return OMIN[DW-1:0];
    return s[DW-1:0];
  endfunction

  logic signed [ACCW-1:0] tr   [NOC][LV+1][2*NIC];
  logic [LV:0]            sv;
  logic [AW-1:0]          sa   [LV+1];
  logic signed [ACCW-1:0] mem  [NOC][DEPTH];
  logic [DEPTH-1:0]       live;
  logic signed [ACCW-1:0] hold [NOC];
  logic                   hold_vld;
  logic [AW-1:0]          hold_addr;

  wire          acc_vld  = sv[LV];
  wire [AW-1:0] acc_addr = sa[LV];
  wire          hit      = hold_vld && (hold_addr == acc_addr);
  wire          mem_we   = acc_vld && !clr && hold_vld && !hit;
  wire          rd_hit   = hold_vld && (hold_addr == rd_addr);

  always_ff @(posedge clk) begin
    for (int o = 0; o < NOC; o++) begin
      for (int i = 0; i < NIC; i++)
        tr[o][0][i] <= mul(px[i*DW +: DW], wt[(o*NIC+i)*DW +: DW]);
      for (int l = 1; l <= LV; l++)
        for (int i = 0; i < NIC; i++)
          tr[o][l][i] <= tr[o][l-1][2*i] + tr[o][l-1][2*i+1];
    end
    sa[0] <= in_addr;
    for (int l = 1; l <= LV; l++) sa[l] <= sa[l-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sv <= '0;
    else        sv <= {sv[LV-1+(LV==0):0], in_vld} & {(LV+1){1'b1}};

  generate
    for (genvar o = 0; o < NOC; o++) begin : g_bank
      wire signed [ACCW-1:0] base = hit ? hold[o] :
                                    (live[acc_addr] ? mem[o][acc_addr] : '0);
      always_ff @(posedge clk) begin
        if (mem_we) mem[o][hold_addr] <= hold[o];
        if (acc_vld && !clr) hold[o] <= base + tr[o][LV][0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      live      <= '0;
      hold_vld  <= 1'b0;
      hold_addr <= '0;
    end else if (clr) begin
      live      <= '0;
      hold_vld  <= 1'b0;
    end else begin
      if (mem_we) live[hold_addr] <= 1'b1;
      if (acc_vld) begin
        hold_vld  <= 1'b1;
        hold_addr <= acc_addr;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rd_q   <= '0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en)
        for (int o = 0; o < NOC; o++)
          rd_q[o*DW +: DW] <= narrow(rd_hit ? hold[o] :
                                     (live[rd_addr] ? mem[o][rd_addr] : '0));
    end

  p_drain_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);
  p_clear_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hold_vld);
  p_hold_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !clr) |=> (hold_vld && hold_addr == $past(acc_addr)));
  p_writeback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (hold_vld && acc_vld && acc_addr != hold_addr));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_vld && !clr) |=> ($stable(hold_vld) && $stable(hold_addr)));

endmodule

// File: tb/sim_chan_mac_engine.sv
`timescale 1ns/1ps
module sim_chan_mac_engine;
  localparam int NOC = 4, NIC = 4, DW = 12, FRAC = 8, DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, clr = 0, in_vld = 0, rd_en = 0;
  logic [AW-1:0] in_addr = '0, rd_addr = '0;
  logic [NIC*DW-1:0] px = '0;
  logic [NOC*NIC*DW-1:0] wt = '0;
  logic rd_vld;
  logic [NOC*DW-1:0] rd_q;

  int checks = 0, errors = 0;
  int pxv [NIC];
  int wtv [NOC][NIC];
  longint refm [DEPTH][NOC];

  always #4 clk = ~clk;

  chan_mac_engine #(.NOC(NOC), .NIC(NIC), .DW(DW), .FRAC(FRAC), .DEPTH(DEPTH)) u0 (
    .clk, .rst_n, .clr, .in_vld, .in_addr, .px, .wt, .rd_en, .rd_addr, .rd_vld, .rd_q);

  function automatic int expect_of(longint a);
    longint s = (a + (64'sd1 <<< (FRAC-1))) >>> FRAC;
    if (s > 2047) s = 2047;
    if (s < -2048) s = -2048;
    return int'(s);
  endfunction

  task automatic issue(int a);
    for (int i = 0; i < NIC; i++) px[i*DW +: DW] = pxv[i][DW-1:0];
    for (int o = 0; o < NOC; o++) begin
      for (int i = 0; i < NIC; i++) begin
        wt[(o*NIC+i)*DW +: DW] = wtv[o][i][DW-1:0];
        refm[a][o] += longint'(pxv[i]) * longint'(wtv[o][i]);
      end
    end
    in_addr = AW'(a);
    in_vld = 1;
    @(negedge clk);
  endtask

  task automatic settle();
    in_vld = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic load(int pbase, int wbase);
    for (int i = 0; i < NIC; i++) pxv[i] = pbase + 37*i;
    for (int o = 0; o < NOC; o++)
      for (int i = 0; i < NIC; i++) wtv[o][i] = wbase - 29*o + 11*i;
  endtask

  task automatic check_addr(string req, int a);
    rd_addr = AW'(a);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    checks++;
    if (rd_vld !== 1'b1) begin
      errors++;
      $display("FAIL %s rd_vld addr %0d actual %b expected 1", req, a, rd_vld);
    end
    for (int o = 0; o < NOC; o++) begin
      int got = int'($signed(rd_q[o*DW +: DW]));
      int exp = expect_of(refm[a][o]);
      checks++;
      if (got != exp) begin
        errors++;
        $display("FAIL %s addr %0d ch %0d actual %0d expected %0d", req, a, o, got, exp);
      end
    end
  endtask

  task automatic t_reset();
    checks++;
    if (rd_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1 rd_vld actual %b expected 0", rd_vld);
    end
    check_addr("R1", 0);
    check_addr("R1", 7);
    check_addr("R1", DEPTH-1);
  endtask

  task automatic t_basic();
    load(100, 300);
    issue(1);
    settle();
    check_addr("R2", 1);
    check_addr("R2", 0);
  endtask

  task automatic t_spaced();
    load(-200, 150);
    issue(2);
    settle();
    load(90, -60);
    issue(2);
    settle();
    check_addr("R3", 2);
  endtask

  task automatic t_b2b();
    load(50, 400);
    issue(3);
    load(-70, 120);
    issue(3);
    load(210, -90);
    issue(3);
    issue(3);
    settle();
    check_addr("R4", 3);
  endtask

  task automatic t_dist2();
    load(120, 80);
    issue(4);
    load(-40, 250);
    issue(5);
    load(300, -150);
    issue(4);
    load(15, 60);
    issue(5);
    load(-90, -110);
    issue(4);
    settle();
    check_addr("R5", 4);
    check_addr("R5", 5);
  endtask

  task automatic t_novalid();
    load(500, 500);
    for (int i = 0; i < NIC; i++) px[i*DW +: DW] = 12'h3ff;
    wt = {NOC*NIC{12'h3ff}};
    in_addr = AW'(1);
    in_vld = 0;
    repeat (4) @(negedge clk);
    settle();
    check_addr("R9", 1);
  endtask

  task automatic t_clear();
    load(33, 44);
    issue(9);
    settle();
    clr = 1;
    @(negedge clk);
    clr = 0;
    for (int a = 0; a < DEPTH; a++)
      for (int o = 0; o < NOC; o++) refm[a][o] = 0;
    settle();
    check_addr("R6", 9);
    check_addr("R6", 3);
    check_addr("R6", 1);
    load(20, 30);
    issue(9);
    settle();
    check_addr("R6", 9);
  endtask

  task automatic t_round();
    for (int i = 0; i < NIC; i++) pxv[i] = 0;
    pxv[0] = 1;
    for (int o = 0; o < NOC; o++)
      for (int i = 0; i < NIC; i++) wtv[o][i] = 0;
    wtv[0][0] = 128;
    wtv[1][0] = 127;
    wtv[2][0] = -128;
    wtv[3][0] = -129;
    issue(10);
    settle();
    check_addr("R7", 10);
  endtask

  task automatic t_sat();
    for (int i = 0; i < NIC; i++) pxv[i] = 2047;
    for (int o = 0; o < NOC; o++)
      for (int i = 0; i < NIC; i++) wtv[o][i] = (o % 2 == 0) ? 2047 : -2048;
    issue(11);
    settle();
    check_addr("R8", 11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++)
      for (int o = 0; o < NOC; o++) refm[a][o] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_spaced();
    t_b2b();
    t_dist2();
    t_novalid();
    t_round();
    t_sat();
    t_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule